// File: doc/BRIEF.md
# Programmable Sum-of-Products Plane

This block is the configurable AND-OR plane of a small generic logic device. Twelve dedicated inputs and ten feedback signals from the output cells form a 22-bit array input vector. Every array input drives a true line and a complement line. Each AND gate picks one of four connections per array input from a configuration word. The plane has ten output cells. Each cell gets the OR of eight product terms and one separate product term that serves as its output enable.

The outputs are purely combinational in the array inputs. The only state is the configuration store. That store is written one product term at a time through a valid/ready port, which carries a cell index, a term index and a 44-bit connection word. A write is accepted in a cycle where `cfg_valid` and `cfg_ready` are both high. While `cfg_ready` is low, the writer must hold its request stable. `cfg_ready` is low during reset and in the first cycle after reset, and high from then on. Synchronous reset returns every crossing to the unprogrammed state.

Top module: `pla_and_or_plane`

## Requirements
- R1: After reset every crossing holds code 11, which connects both lines. Every product term is then false, so `sum_out` and `oe_out` read all zeros for any input pattern.
- R2: `cfg_ready` is low while `rst` is high and in the first cycle after `rst` falls. It is high in every later cycle.
- R3: Each array input i owns bits [2i+1:2i] of a connection word. Bit 2i+1 connects the true line and bit 2i connects the complement line. Code 10 makes the term require input i to be 1.
- R4: Code 01 makes the term require input i to be 0.
- R5: Code 00 leaves input i out of the term. A term whose crossings are all 00 is true.
- R6: Term indices 0..7 feed the OR that drives `sum_out[c]`. Term index 8 alone drives `oe_out[c]`. A write to a summed term never changes `oe_out`.
- R7: `sum_out[c]` is the OR of the eight summed terms of cell c. Array input bits 0..11 are `ded_in[11:0]` and bits 12..21 are `fb_in[9:0]`.
- R8: A write whose cell index is 10 or above, or whose term index is 9 or above, is ignored.
- R9: An accepted write changes the outputs only after the clock edge that accepts it, and takes effect from that cycle on.
- R10: A write to cell c leaves the outputs of every other cell unchanged.
- R11: Asserting reset after programming restores the unprogrammed pattern everywhere.
- R12: Address and word values presented with `cfg_valid` low have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration store |
| rst | input | 1 | Synchronous active-high reset |
| ded_in | input | 12 | Dedicated array inputs (array bits 0..11) |
| fb_in | input | 10 | Feedback from output cells (array bits 12..21) |
| cfg_valid | input | 1 | Configuration write request |
| cfg_ready | output | 1 | Store can accept a write |
| cfg_cell | input | 4 | Output cell index of the write |
| cfg_term | input | 4 | Term index, 0..7 summed, 8 enable |
| cfg_word | input | 44 | Two connection bits per array input |
| sum_out | output | 10 | OR of the eight summed terms per cell |
| oe_out | output | 10 | Enable product term per cell |

## Verification
The bench walks a single-literal term across all 22 array inputs in both polarities. A swapped true/complement bit or a misplaced feedback slice therefore shows up as an inverted or wrong-input output. It writes every illegal cell and term index with an always-true word. A design that wrapped or truncated the address would light an output. Every write is checked just before and just after its accepting edge, with all cells compared, so an early commit or a write that spills into a neighbour cell or into the enable term is visible. A mid-run reset after dense random programming catches a store that failed to return to the blocking code.

// File: rtl/pla_pkg.sv
package pla_pkg;
  localparam int PLA_N_DED  = 12;
  localparam int PLA_N_CELL = 10;
  localparam int PLA_N_SUM  = 8;

  typedef enum logic [1:0] {
    XING_OPEN  = 2'b00,
    XING_COMP  = 2'b01,
    XING_TRUE  = 2'b10,
    XING_BLOCK = 2'b11
  } xing_e;

  // A crossing forces its term false when a connected line sits at 0.
  function automatic logic xing_kills(logic [1:0] code, logic v);
    return (code[1] & ~v) | (code[0] & v);
  endfunction
endpackage

// File: rtl/pla_term.sv
module pla_term
  import pla_pkg::*;
#(
  parameter int N_IN = 22,
  localparam int W_WORD = 2 * N_IN
) (
  input  logic [N_IN-1:0]   x,
  input  logic [W_WORD-1:0] word,
  output logic              pt
);
  always_comb begin
    pt = 1'b1;
    for (int i = 0; i < N_IN; i++) begin
      if (xing_kills(word[2*i +: 2], x[i])) pt = 1'b0;
    end
  end
endmodule

// File: rtl/pla_cell.sv
module pla_cell #(
  parameter int N_IN  = 22,
  parameter int N_SUM = 8,
  localparam int N_TERM = N_SUM + 1,
  localparam int W_WORD = 2 * N_IN
) (
  input  logic [N_IN-1:0]               x,
  input  logic [N_TERM-1:0][W_WORD-1:0] words,
  output logic                          sum_o,
  output logic                          oe_o
);
  logic [N_TERM-1:0] pts;

  for (genvar t = 0; t < N_TERM; t++) begin : g_term
    pla_term #(.N_IN(N_IN)) u_term (
      .x    (x),
      .word (words[t]),
      .pt   (pts[t])
    );
  end

  assign sum_o = |pts[N_SUM-1:0];
  assign oe_o  = pts[N_SUM];
endmodule

// File: rtl/pla_cfg_store.sv
module pla_cfg_store #(
  parameter int N_CELL = 10,
  parameter int N_TERM = 9,
  parameter int W_WORD = 44,
  localparam int CELL_W = $clog2(N_CELL),
  localparam int TERM_W = $clog2(N_TERM)
) (
  input  logic                                      clk,
  input  logic                                      rst,
  input  logic                                      wr_en,
  input  logic [CELL_W-1:0]                         wr_cell,
  input  logic [TERM_W-1:0]                         wr_term,
  input  logic [W_WORD-1:0]                         wr_word,
  output logic [N_CELL-1:0][N_TERM-1:0][W_WORD-1:0] cfg_q
);
  // Reset fills every crossing with the blocking code (both lines tied).
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '1;
    end else if (wr_en) begin
      cfg_q[wr_cell][wr_term] <= wr_word;
    end
  end
endmodule

// File: rtl/pla_and_or_plane.sv
module pla_and_or_plane
  import pla_pkg::*;
#(
  parameter int N_DED  = PLA_N_DED,
  parameter int N_CELL = PLA_N_CELL,
  parameter int N_SUM  = PLA_N_SUM,
  localparam int N_IN   = N_DED + N_CELL,
  localparam int N_TERM = N_SUM + 1,
  localparam int W_WORD = 2 * N_IN,
  localparam int CELL_W = $clog2(N_CELL),
  localparam int TERM_W = $clog2(N_TERM)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_DED-1:0]  ded_in,
  input  logic [N_CELL-1:0] fb_in,
  input  logic              cfg_valid,
  output logic              cfg_ready,
  input  logic [CELL_W-1:0] cfg_cell,
  input  logic [TERM_W-1:0] cfg_term,
  input  logic [W_WORD-1:0] cfg_word,
  output logic [N_CELL-1:0] sum_out,
  output logic [N_CELL-1:0] oe_out
);
  logic                                      ready_q;
  logic                                      addr_ok;
  logic                                      wr_en;
  logic [N_IN-1:0]                           arr_in;
  logic [N_CELL-1:0][N_TERM-1:0][W_WORD-1:0] cfg_q;

  always_ff @(posedge clk) begin
    if (rst) ready_q <= 1'b0;
    else     ready_q <= 1'b1;
  end

  assign cfg_ready = ready_q;
  assign addr_ok   = (int'(cfg_cell) < N_CELL) && (int'(cfg_term) < N_TERM);
  assign wr_en     = cfg_valid && ready_q && addr_ok;
  assign arr_in    = {fb_in, ded_in};

  pla_cfg_store #(
    .N_CELL (N_CELL),
    .N_TERM (N_TERM),
    .W_WORD (W_WORD)
  ) u_store (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_cell (cfg_cell),
    .wr_term (cfg_term),
    .wr_word (cfg_word),
    .cfg_q   (cfg_q)
  );

  for (genvar c = 0; c < N_CELL; c++) begin : g_cell
    pla_cell #(.N_IN(N_IN), .N_SUM(N_SUM)) u_cell (
      .x     (arr_in),
      .words (cfg_q[c]),
      .sum_o (sum_out[c]),
      .oe_o  (oe_out[c])
    );
  end
endmodule

// File: rtl/pla_and_or_plane_chk.sv
module pla_and_or_plane_chk #(
  parameter int N_DED  = 12,
  parameter int N_CELL = 10,
  parameter int N_SUM  = 8,
  localparam int N_TERM = N_SUM + 1,
  localparam int CELL_W = $clog2(N_CELL),
  localparam int TERM_W = $clog2(N_TERM)
) (
  input logic              clk,
  input logic              rst,
  input logic [N_DED-1:0]  ded_in,
  input logic [N_CELL-1:0] fb_in,
  input logic              cfg_valid,
  input logic              cfg_ready,
  input logic [CELL_W-1:0] cfg_cell,
  input logic [TERM_W-1:0] cfg_term,
  input logic [N_CELL-1:0] sum_out,
  input logic [N_CELL-1:0] oe_out
);
  logic              hit;
  logic              hit_sum;
  logic              prog_seen;
  logic [N_CELL-1:0] hit_mask;

  assign hit = cfg_valid && cfg_ready &&
               (int'(cfg_cell) < N_CELL) && (int'(cfg_term) < N_TERM);
  assign hit_sum = hit && (int'(cfg_term) < N_SUM);

  always_comb begin
    hit_mask = '0;
    for (int c = 0; c < N_CELL; c++) begin
      if (hit && int'(cfg_cell) == c) hit_mask[c] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)      prog_seen <= 1'b0;
    else if (hit) prog_seen <= 1'b1;
  end

  // R2
  ready_recovers_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_ready |=> cfg_ready);

  // R1
  blank_outputs_chk: assert property (@(posedge clk) disable iff (rst)
    !prog_seen |-> (sum_out == '0 && oe_out == '0));

  // R8
  no_stray_change_chk: assert property (@(posedge clk) disable iff (rst)
    ($stable(ded_in) && $stable(fb_in) && !$past(rst) && !$past(hit))
      |-> ($stable(sum_out) && $stable(oe_out)));

  // R10
  other_cells_chk: assert property (@(posedge clk) disable iff (rst)
    ($stable(ded_in) && $stable(fb_in) && !$past(rst))
      |-> (((sum_out ^ $past(sum_out)) & ~$past(hit_mask)) == '0 &&
           ((oe_out ^ $past(oe_out)) & ~$past(hit_mask)) == '0));

  // R6
  oe_isolation_chk: assert property (@(posedge clk) disable iff (rst)
    ($stable(ded_in) && $stable(fb_in) && !$past(rst) && $past(hit_sum))
      |-> $stable(oe_out));
endmodule

bind pla_and_or_plane pla_and_or_plane_chk #(
  .N_DED  (N_DED),
  .N_CELL (N_CELL),
  .N_SUM  (N_SUM)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ded_in    (ded_in),
  .fb_in     (fb_in),
  .cfg_valid (cfg_valid),
  .cfg_ready (cfg_ready),
  .cfg_cell  (cfg_cell),
  .cfg_term  (cfg_term),
  .sum_out   (sum_out),
  .oe_out    (oe_out)
);

// File: tb/pla_and_or_plane_test.sv
`timescale 1ns/1ps
module pla_and_or_plane_test;
  localparam int NC = 10;
  localparam int NS = 8;
  localparam int NT = 9;
  localparam int NI = 22;
  localparam int WW = 44;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [11:0]   ded_in = '0;
  logic [9:0]    fb_in = '0;
  logic          cfg_valid = 1'b0;
  logic          cfg_ready;
  logic [3:0]    cfg_cell = '0;
  logic [3:0]    cfg_term = '0;
  logic [WW-1:0] cfg_word = '0;
  logic [9:0]    sum_out;
  logic [9:0]    oe_out;

  int n_checks = 0;
  int n_errors = 0;
  logic [WW-1:0] mdl [NC][NT];
  logic [NI-1:0] xin = '0;

  always #4 clk = ~clk;

  pla_and_or_plane uut (
    .clk(clk), .rst(rst), .ded_in(ded_in), .fb_in(fb_in),
    .cfg_valid(cfg_valid), .cfg_ready(cfg_ready), .cfg_cell(cfg_cell),
    .cfg_term(cfg_term), .cfg_word(cfg_word), .sum_out(sum_out), .oe_out(oe_out)
  );

  task automatic mdl_blank();
    for (int c = 0; c < NC; c++)
      for (int t = 0; t < NT; t++) mdl[c][t] = '1;
  endtask

  task automatic set_in(logic [NI-1:0] v);
    xin = v;
    ded_in = v[11:0];
    fb_in = v[21:12];
  endtask

  task automatic check_bit(string tag, logic act, logic exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    logic [9:0] es, eo;
    es = '0;
    eo = '0;
    for (int c = 0; c < NC; c++) begin
      for (int t = 0; t < NT; t++) begin
        logic pt;
        pt = 1'b1;
        for (int i = 0; i < NI; i++) begin
          if (mdl[c][t][2*i+1] && !xin[i]) pt = 1'b0;
          if (mdl[c][t][2*i] && xin[i]) pt = 1'b0;
        end
        if (t < NS) es[c] = es[c] | pt;
        else eo[c] = pt;
      end
    end
    n_checks++;
    if (sum_out !== es || oe_out !== eo) begin
      n_errors++;
      $display("FAIL %s: actual sum=%h oe=%h expected sum=%h oe=%h",
               tag, sum_out, oe_out, es, eo);
    end
  endtask

  task automatic wr(int c, int t, logic [WW-1:0] w);
    @(negedge clk);
    cfg_valid = 1'b1;
    cfg_cell = 4'(c);
    cfg_term = 4'(t);
    cfg_word = w;
    #1 check_all("R9 before accepting edge");
    @(negedge clk);
    cfg_valid = 1'b0;
    if (c < NC && t < NT) mdl[c][t] = w;
    #1 check_all("R9/R10 after accepting edge");
  endtask

  function automatic logic [WW-1:0] one_lit(int i, logic [1:0] code);
    logic [WW-1:0] w;
    w = '0;
    w[2*i +: 2] = code;
    return w;
  endfunction

  initial begin
    #(8 * 150000);
    n_errors++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    mdl_blank();
    repeat (3) @(negedge clk);
    check_bit("R2 ready low in reset", cfg_ready, 1'b0);
    rst = 1'b0;
    #1 check_bit("R2 ready low first cycle", cfg_ready, 1'b0);
    @(negedge clk);
    #1 check_bit("R2 ready high after", cfg_ready, 1'b1);

    // R1: blank plane for many patterns
    for (int k = 0; k < 40; k++) begin
      set_in(NI'($urandom));
      #1 check_all("R1 blank plane");
      @(negedge clk);
    end

    // R3 / R4: single literal on every array input, both polarities
    for (int i = 0; i < NI; i++) begin
      for (int p = 0; p < 2; p++) begin
        int c, t;
        c = i % NC;
        t = i % NS;
        wr(c, t, one_lit(i, p == 0 ? 2'b10 : 2'b01));
        set_in('0);
        #1 check_bit(p == 0 ? "R3 true lit x=0" : "R4 comp lit x=0", sum_out[c], p[0]);
        set_in(NI'(1) << i);
        #1 check_bit(p == 0 ? "R3 true lit x=1" : "R4 comp lit x=1", sum_out[c], ~p[0]);
        set_in(~(NI'(1) << i));
        #1 check_all("R7 single literal other inputs");
        wr(c, t, '1);
      end
    end

    // R5: all-open term is true for any input
    wr(3, 5, '0);
    for (int k = 0; k < 16; k++) begin
      set_in(NI'($urandom));
      #1 check_bit("R5 open term true", sum_out[3], 1'b1);
      check_all("R5/R6 open term oe untouched");
    end

    // R6: enable term drives only oe_out
    wr(3, 5, '1);
    wr(7, 8, one_lit(14, 2'b10));
    set_in(NI'(1) << 14);
    #1 check_bit("R6 oe term high", oe_out[7], 1'b1);
    check_bit("R6 sum unaffected", sum_out[7], 1'b0);
    set_in('0);
    #1 check_bit("R6 oe term low", oe_out[7], 1'b0);
    wr(7, 8, '1);

    // R8: every illegal address with an always-true word
    for (int c = 0; c < 16; c++)
      for (int t = 0; t < 16; t++)
        if (c >= NC || t >= NT) begin
          wr(c, t, '0);
          check_bit("R8 illegal write ignored", |{sum_out, oe_out}, 1'b0);
        end

    // R12: payload without valid
    @(negedge clk);
    cfg_cell = 4'd2; cfg_term = 4'd0; cfg_word = '0;
    @(negedge clk);
    #1 check_bit("R12 no valid no write", sum_out[2], 1'b0);

    // R7: dense random programming, compared across many patterns
    for (int c = 0; c < NC; c++)
      for (int t = 0; t < NT; t++) begin
        logic [WW-1:0] w;
        w = '0;
        for (int k = 0; k < 1 + (c + t) % 3; k++)
          w[2 * ($urandom % NI) +: 2] = ($urandom % 2) ? 2'b10 : 2'b01;
        wr(c, t, w);
      end
    for (int k = 0; k < 200; k++) begin
      set_in(NI'($urandom));
      #1 check_all("R7 sum of products");
      @(negedge clk);
    end

    // R11: reset restores blocking pattern
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    mdl_blank();
    for (int k = 0; k < 20; k++) begin
      set_in(NI'($urandom));
      #1 check_all("R11 reset restores blank");
      @(negedge clk);
    end

    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule